// File: doc/BRIEF.md
# Pseudo-Random Memory Self-Test Sequencer

This block checks a large external memory without holding any copy of the data it writes. It sits in front of a memory controller that offers a simple request/acknowledge port in the style of a static RAM. That controller hides row opening, bank selection and refresh, and it may take any number of cycles per access. A start pulse latches a seed. The sequencer then sweeps the whole address range twice.

In the first sweep it writes every word with the output of a linear-feedback shift register (LFSR). In the second sweep it reloads the LFSR from the same latched seed and reads the words back in the same order. It compares each word with the regenerated value. A clean sweep ends in a pass flag. The first mismatch stops the sequencer with a fail flag and records where the mismatch happened and what was seen.

Top module: `memtest_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `mem_req` are all low.
- R2: A `start` pulse sampled while `busy` is low begins a test, and `busy` is high from the next cycle until the cycle in which `done` rises. A `start` sampled while `busy` is high is ignored, and so is any change on `seed` while `busy` is high.
- R3: In the fill sweep, words are written with `mem_we`=1 to addresses 0 to 2^ADDR_W-1 in ascending order. The first word equals the seed. Each later word is the previous word w advanced one step: `(w >> 1) ^ (w[0] ? TAPS : 0)`, with TAPS = 0xB400 by default.
- R4: A seed of zero is replaced by DEFAULT_SEED (0xACE1 by default), so the first word written is 0xACE1.
- R5: After the last fill write is acknowledged, the sequencer reads addresses 0 to 2^ADDR_W-1 in ascending order with `mem_we`=0. It compares each read word with the same sequence, restarted from the latched seed.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values, for any number of wait cycles.
- R7: The generator and the address advance only on an acknowledged transaction. A passing test therefore performs exactly 2^ADDR_W writes and 2^ADDR_W reads.
- R8: When every read word matches, `pass` and `done` are high and `busy` is low in the cycle after the final acknowledge. These flags hold until the next `start`.
- R9: On the first mismatching read, `fail` and `done` rise in the next cycle. `fail_addr` shows the read address, `fail_exp` the regenerated word and `fail_got` the word read. No further request is issued, and all of these hold until the next `start`.
- R10: `pass` and `fail` are never high together, and `done` is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test (ignored while busy) |
| seed | input | DATA_W | Generator seed, latched at start |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transaction completes this cycle |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished (pass or fail) |
| pass | output | 1 | All words matched |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_exp | output | DATA_W | Expected word at that address |
| fail_got | output | DATA_W | Word actually read |

## Verification
`busy` is due one clock edge after `start` is sampled. Each new address and data word is due one edge after the acknowledge that retires the previous one. `pass`, `fail` and the captured mismatch fields are due one edge after the final or failing acknowledge. The bench drives `start` and the memory responses on the falling edge and reads the outputs there too, so every value it checks has exactly one rising edge behind it. Result checks are made on the first falling edge at which `done` is high, with the expected words computed from the stated recurrence.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } mt_state_e;
endpackage

// File: rtl/memtest_lfsr.sv
module memtest_lfsr #(
    parameter int unsigned          W            = 16,
    parameter logic [W-1:0]         TAPS         = 'hB400,
    parameter logic [W-1:0]         DEFAULT_SEED = 'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = (seed == '0) ? DEFAULT_SEED : seed;
        end else if (step) begin
            val_d = {1'b0, val_q[W-1:1]} ^ (val_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= DEFAULT_SEED;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/memtest_addr_ctr.sv
module memtest_addr_ctr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] TOP = '1;

    logic [AW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr = cnt_q;
    assign last = (cnt_q == TOP);
endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         match
);
    logic [W-1:0] same;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign same[i] = a[i] ~^ b[i];
    end

    assign match = &same;
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int unsigned           ADDR_W       = 8,
    parameter int unsigned           DATA_W       = 16,
    parameter logic [DATA_W-1:0]     TAPS         = 'hB400,
    parameter logic [DATA_W-1:0]     DEFAULT_SEED = 'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] seed,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    typedef struct packed {
        mt_state_e         st;
        logic [DATA_W-1:0] seed;
        logic [ADDR_W-1:0] f_addr;
        logic [DATA_W-1:0] f_exp;
        logic [DATA_W-1:0] f_got;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              gen_load, gen_step, ctr_clr, ctr_inc;
    logic [DATA_W-1:0] gen_seed, gen_val;
    logic [ADDR_W-1:0] ctr_addr;
    logic              ctr_last, word_ok;
    logic              active;

    memtest_lfsr #(
        .W(DATA_W), .TAPS(TAPS), .DEFAULT_SEED(DEFAULT_SEED)
    ) gen_i (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .seed(gen_seed), .value(gen_val)
    );

    memtest_addr_ctr #(.AW(ADDR_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc),
        .addr(ctr_addr), .last(ctr_last)
    );

    memtest_cmp #(.W(DATA_W)) cmp_i (
        .a(mem_rdata), .b(gen_val), .match(word_ok)
    );

    assign active = (regs_q.st == ST_FILL) || (regs_q.st == ST_CHECK);

    always_comb begin
        regs_d   = regs_q;
        gen_load = 1'b0;
        gen_step = 1'b0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        gen_seed = active ? regs_q.seed : seed;
        case (regs_q.st)
            ST_FILL: begin
                if (mem_ack) begin
                    if (ctr_last) begin
                        regs_d.st = ST_CHECK;
                        gen_load  = 1'b1;
                        ctr_clr   = 1'b1;
                    end else begin
                        gen_step = 1'b1;
                        ctr_inc  = 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (mem_ack) begin
                    if (!word_ok) begin
                        regs_d.st     = ST_FAIL;
                        regs_d.f_addr = ctr_addr;
                        regs_d.f_exp  = gen_val;
                        regs_d.f_got  = mem_rdata;
                    end else if (ctr_last) begin
                        regs_d.st = ST_PASS;
                    end else begin
                        gen_step = 1'b1;
                        ctr_inc  = 1'b1;
                    end
                end
            end
            default: begin
                if (start) begin
                    regs_d.st     = ST_FILL;
                    regs_d.seed   = seed;
                    regs_d.f_addr = '0;
                    regs_d.f_exp  = '0;
                    regs_d.f_got  = '0;
                    gen_load      = 1'b1;
                    ctr_clr       = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.st     <= ST_IDLE;
            regs_q.seed   <= '0;
            regs_q.f_addr <= '0;
            regs_q.f_exp  <= '0;
            regs_q.f_got  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_req   = active;
    assign mem_we    = (regs_q.st == ST_FILL);
    assign mem_addr  = ctr_addr;
    assign mem_wdata = gen_val;
    assign busy      = active;
    assign pass      = (regs_q.st == ST_PASS);
    assign fail      = (regs_q.st == ST_FAIL);
    assign done      = pass | fail;
    assign fail_addr = regs_q.f_addr;
    assign fail_exp  = regs_q.f_exp;
    assign fail_got  = regs_q.f_got;
endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr
);
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_not_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    assert_verify_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req) && $past(mem_we)) |-> (mem_addr == '0));

    assert_pass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !start) |=> pass);

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr)));

    assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !mem_req);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail) && (done == (pass || fail)));
endmodule

bind memtest_seq memtest_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr)
);

// File: tb/memtest_seq_tb_top.sv
module memtest_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int N  = 1 << AW;
    localparam logic [DW-1:0] TAPS  = 16'hB400;
    localparam logic [DW-1:0] DSEED = 16'hACE1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] seed = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          busy, done, pass, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memtest_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    // behavioural memory with variable latency
    logic [DW-1:0] mem [N];
    int  lat_mode = 0;
    bit  corrupt_en = 0;
    int  corrupt_at = 0;
    int  wr_cnt = 0, rd_cnt = 0, txn = 0, wait_cnt = 0, stab_err = 0;
    bit  pend = 0;
    logic          p_we;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
            pend = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            pend = 0;
            txn++;
            wait_cnt = (lat_mode == 0) ? 0 : (int'(mem_addr) * 3 + txn) % (lat_mode + 1);
        end else if (mem_req) begin
            if (pend && (p_we != mem_we || p_addr != mem_addr || p_wdata != mem_wdata))
                stab_err++;
            pend = 1;
            p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
            if (wait_cnt == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = (corrupt_en && int'(mem_addr) == corrupt_at)
                                    ? (mem_wdata ^ 16'h0001) : mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_cnt++;
                end
            end else begin
                wait_cnt--;
            end
        end
    end

    int checks = 0, fails = 0;
    logic [DW-1:0] exp_w [N];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic build_exp(input logic [DW-1:0] s);
        logic [DW-1:0] w;
        w = (s == '0) ? DSEED : s;
        for (int i = 0; i < N; i++) begin
            exp_w[i] = w;
            w = (w >> 1) ^ (w[0] ? TAPS : '0);
        end
    endtask

    // run one test; poke_at > 0 pulses start with another seed mid-run
    task automatic run(input logic [DW-1:0] s, input int lat, input bit cor,
                       input int cor_at, input int poke_at);
        int cyc;
        bit busy_drop;
        lat_mode = lat; corrupt_en = cor; corrupt_at = cor_at;
        wr_cnt = 0; rd_cnt = 0; stab_err = 0;
        for (int i = 0; i < N; i++) mem[i] = '0;
        build_exp(s);
        @(negedge clk); seed = s; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R2", "busy after start", busy, 1);
        cyc = 0; busy_drop = 0;
        while (!done && cyc < 5000) begin
            if (cyc == poke_at && poke_at > 0) begin start = 1'b1; seed = s ^ 16'h5A5A; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
            if (!done && !busy) busy_drop = 1;
        end
        start = 1'b0;
        check(cyc < 5000, "R2", "watchdog", cyc, 0);
        check(!busy_drop && !busy, "R2", "busy window", busy_drop, 0);
        check(stab_err == 0, "R6", "request stable while waiting", stab_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !pass && !fail && !mem_req, "R1", "reset flags",
              {busy, done, pass, fail, mem_req}, 0);
        rst_n = 1'b1;

        // clean pass, per-address sweep of fill contents
        run(16'h1234, 3, 0, 0, 0);
        for (int a = 0; a < N; a++)
            check(mem[a] == exp_w[a], "R3", $sformatf("fill word %0d", a), mem[a], exp_w[a]);
        check(pass && !fail && done, "R8", "pass flags", {pass, fail, done}, 3'b101);
        check(wr_cnt == N && rd_cnt == N, "R7", "transaction counts", wr_cnt * 100 + rd_cnt, N * 101);
        repeat (4) @(negedge clk);
        check(pass && done && !busy, "R8", "pass held", pass, 1);

        // zero seed substitution
        run(16'h0000, 0, 0, 0, 0);
        check(mem[0] == DSEED, "R4", "zero seed replaced", mem[0], DSEED);
        check(mem[N-1] == exp_w[N-1], "R4", "last word default seq", mem[N-1], exp_w[N-1]);
        check(pass, "R5", "pass with default seed", pass, 1);

        // start and seed change while busy are ignored
        run(16'h00F1, 2, 0, 0, 7);
        check(mem[0] == 16'h00F1 && mem[N-1] == exp_w[N-1], "R2", "restart ignored", mem[0], 16'h00F1);
        check(pass && wr_cnt == N && rd_cnt == N, "R5", "verify used latched seed", pass, 1);

        // mismatches at first, middle, last address, several latencies
        for (int k = 0; k < 3; k++) begin
            int at;
            at = (k == 0) ? 0 : (k == 1) ? 5 : N - 1;
            run(16'hBEEF + 16'(k), k + 1, 1, at, 0);
            check(fail && !pass && done, "R9", $sformatf("fail flags at %0d", at), {fail, pass}, 2'b10);
            check(int'(fail_addr) == at, "R9", "fail_addr", fail_addr, at);
            check(fail_exp == exp_w[at], "R9", "fail_exp", fail_exp, exp_w[at]);
            check(fail_got == (exp_w[at] ^ 16'h0001), "R9", "fail_got", fail_got, exp_w[at] ^ 16'h0001);
            check(rd_cnt == at + 1, "R7", "reads before stop", rd_cnt, at + 1);
            repeat (5) @(negedge clk);
            check(!mem_req && fail && rd_cnt == at + 1, "R9", "no requests after fail", mem_req, 0);
            check(!(pass && fail) && done == (pass || fail), "R10", "flag exclusivity", {pass, fail, done}, 3'b011);
        end

        // latency sweep with clean memory
        for (int l = 0; l < 5; l++) begin
            run(16'h0101 * 16'(l + 1), l, 0, 0, 0);
            check(pass && rd_cnt == N, "R6", $sformatf("pass with latency mode %0d", l), pass, 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule